// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block collects interrupt requests from a parameterised set of peripheral lines, four fixed exception lines that can never be masked, three debug event lines, and one lowest-tier software request. It picks a single winner and presents it to the processor core. The winner comes with its global source number, its priority tier and the address of its handler. Each peripheral line carries a programmable two-bit priority code and a programmable edge or level capture mode. The core supplies its current mask level. When software raises that mask to one tier above the handler it is running, only higher tiers reach it, so handlers can nest.

Handler addresses are formed from a relocatable base register. One fast-interrupt slot can point at any single source and replace that source's address with a dedicated vector. An acknowledge pulse from the core consumes the presented request and records the tier being serviced. A wake output tells the clock controller that some enabled request is pending, whatever the mask.

Configuration goes through a single write port. The select code chooses a register: 0 peripheral priority, 1 peripheral capture mode, 2 vector base, 3 fast slot (bits 7:0 source, bit 8 enable), 4 fast vector.

Top module: `prio_intc`

## Requirements
- R1: After synchronous reset, req_o, wake_o, req_fast_o, req_src_o, req_lvl_o, req_vec_o and svc_lvl_o are all zero. While req_o is low, req_fast_o and req_vec_o stay zero.
- R2: Tier codes are LP=0, L0=1, L1=2, L2=3, L3=4. Peripheral j has global source number 8+j. Its priority code 1, 2 or 3 maps to tier L0, L1 or L2, and code 0 (the reset value) disables it entirely.
- R3: Among eligible requests, the highest tier wins. Within one tier, the lowest global source number wins.
- R4: A maskable request is presented only when its tier code is greater than or equal to core_mask_i. A mask of 5 or more blocks every maskable source.
- R5: Exception lines 0..3 are sources 0..3 at tier L3 and are presented whatever the mask. Debug lines 0..2 are sources 4..6 at tier L3 and obey the mask.
- R6: The software request is source 7 at tier LP.
- R7: An acknowledge while req_o is high stores the presented tier in svc_lvl_o on the next cycle. With the mask raised above that tier, a higher-tier request is still presented.
- R8: Exception lines, and peripherals set to edge mode (capture code 1), latch a rising edge and stay pending after the line drops until they are acknowledged. Level-mode sources follow their line.
- R9: With no fast match, req_vec_o equals the base register plus two times the source number. Rewriting the base moves every such address.
- R10: When fast is enabled and the winner equals the fast source, req_fast_o is high and req_vec_o equals the fast vector.
- R11: wake_o is high whenever an enabled request is pending, even when the mask blocks it.
- R12: Outputs reflect an input change on the second rising edge after it, and reflect an acknowledge on the second rising edge after the acknowledge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_SRC | Peripheral request lines |
| exc_i | input | 4 | Unmaskable exception lines |
| dbg_i | input | 3 | Maskable debug event lines |
| sw_lp_i | input | 1 | Lowest-tier software request |
| core_mask_i | input | 3 | Current core mask tier |
| ack_i | input | 1 | Acknowledge of the presented request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_idx_i | input | 8 | Peripheral index for select 0 and 1 |
| cfg_data_i | input | 16 | Configuration write data |
| req_o | output | 1 | Request presented to the core |
| req_src_o | output | 8 | Global source number of the winner |
| req_lvl_o | output | 3 | Tier code of the winner |
| req_vec_o | output | 16 | Handler address |
| req_fast_o | output | 1 | Winner uses the fast vector |
| wake_o | output | 1 | Wake request to the clock controller |
| svc_lvl_o | output | 3 | Tier recorded at the last acknowledge |

## Verification
The assertions assume core_mask_i is a held value that the core changes only between cycles, and that ack_i is a one-cycle pulse given only while req_o is high. The stimulus drives every input on the falling clock edge. It raises ack_i only after it has seen a request presented, and holds each pulse for exactly one cycle. Mask changes come only from the bench tasks, never within a cycle, so the check that compares the presented tier with the previous mask always refers to one stable value.

// File: rtl/ic_pkg.sv
package ic_pkg;

    localparam int IDX_W       = 8;
    localparam int VEC_W       = 16;
    localparam int N_EXC       = 4;
    localparam int N_DBG       = 3;
    localparam int SRC_SW      = 7;
    localparam int PERIPH_BASE = 8;

    typedef enum logic [2:0] {
        LVL_LP = 3'd0,
        LVL_0  = 3'd1,
        LVL_1  = 3'd2,
        LVL_2  = 3'd3,
        LVL_3  = 3'd4
    } lvl_e;

    typedef enum logic [2:0] {
        CFG_PRIO     = 3'd0,
        CFG_EDGE     = 3'd1,
        CFG_BASE     = 3'd2,
        CFG_FAST_SRC = 3'd3,
        CFG_FAST_VEC = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] src;
        lvl_e             lvl;
    } win_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] src;
        logic [VEC_W-1:0] vec;
    } fast_cfg_t;

    function automatic lvl_e code_to_lvl(input logic [1:0] code);
        case (code)
            2'd1:    return LVL_0;
            2'd2:    return LVL_1;
            2'd3:    return LVL_2;
            default: return LVL_LP;
        endcase
    endfunction

    function automatic logic passes_mask(input logic [2:0] lvl,
                                         input logic [2:0] mask,
                                         input logic       unmaskable);
        return unmaskable || (lvl >= mask);
    endfunction

endpackage

// File: rtl/ic_cfg.sv
module ic_cfg
    import ic_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_i,
    input  logic [2:0]            sel_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [15:0]           data_i,
    output logic [N_SRC-1:0][1:0] prio_o,
    output logic [N_SRC-1:0]      edge_o,
    output logic [VEC_W-1:0]      base_o,
    output fast_cfg_t             fast_o
);

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(sel_i);

    logic [N_SRC-1:0][1:0] prio_q;
    logic [N_SRC-1:0]      edge_q;
    logic [VEC_W-1:0]      base_q;
    fast_cfg_t             fast_q;

    for (genvar j = 0; j < N_SRC; j++) begin : g_src_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[j] <= 2'd0;
                edge_q[j] <= 1'b0;
            end else if (we_i && idx_i == IDX_W'(j)) begin
                if (sel == CFG_PRIO) prio_q[j] <= data_i[1:0];
                if (sel == CFG_EDGE) edge_q[j] <= data_i[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            fast_q <= '0;
        end else if (we_i) begin
            case (sel)
                CFG_BASE:     base_q <= data_i[VEC_W-1:0];
                CFG_FAST_SRC: begin
                    fast_q.src <= data_i[IDX_W-1:0];
                    fast_q.en  <= data_i[8];
                end
                CFG_FAST_VEC: fast_q.vec <= data_i[VEC_W-1:0];
                default: ;
            endcase
        end
    end

    assign prio_o = prio_q;
    assign edge_o = edge_q;
    assign base_o = base_q;
    assign fast_o = fast_q;

endmodule

// File: rtl/ic_pending.sv
module ic_pending
    import ic_pkg::*;
#(
    parameter int N_TOT = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TOT-1:0]  line_i,
    input  logic [N_TOT-1:0]  edge_mode_i,
    input  logic              clr_i,
    input  logic [IDX_W-1:0]  clr_src_i,
    output logic [N_TOT-1:0]  active_o
);

    logic [N_TOT-1:0] line_q;
    logic [N_TOT-1:0] pend_q;

    for (genvar i = 0; i < N_TOT; i++) begin : g_pend
        logic rise;
        logic hit;
        assign rise = edge_mode_i[i] && line_i[i] && !line_q[i];
        assign hit  = clr_i && (clr_src_i == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                line_q[i] <= line_i[i];
                if (rise)
                    pend_q[i] <= 1'b1;
                else if (hit || !edge_mode_i[i])
                    pend_q[i] <= 1'b0;
            end
        end

        assign active_o[i] = edge_mode_i[i] ? pend_q[i] : line_q[i];
    end

endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter
    import ic_pkg::*;
#(
    parameter int N_TOT = 24
) (
    input  logic [N_TOT-1:0]      active_i,
    input  logic [N_TOT-1:0]      enable_i,
    input  logic [N_TOT-1:0]      unmask_i,
    input  logic [N_TOT-1:0][2:0] lvl_i,
    input  logic [2:0]            mask_i,
    output win_t                  win_o,
    output logic                  wake_o
);

    logic [N_TOT-1:0] cand;
    logic [N_TOT-1:0] live;

    for (genvar i = 0; i < N_TOT; i++) begin : g_cand
        assign live[i] = active_i[i] && enable_i[i];
        assign cand[i] = live[i] && passes_mask(lvl_i[i], mask_i, unmask_i[i]);
    end

    logic             found;
    logic [2:0]       best_lvl;
    logic [IDX_W-1:0] best_src;

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        found    = 1'b0;
        best_lvl = 3'd0;
        best_src = '0;
        for (int i = N_TOT - 1; i >= 0; i--) begin
            if (cand[i] && (!found || lvl_i[i] >= best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl_i[i];
                best_src = IDX_W'(i);
            end
        end
    end

    assign win_o.valid = found;
    assign win_o.src   = best_src;
    assign win_o.lvl   = lvl_e'(best_lvl);
    assign wake_o      = |live;

endmodule

// File: rtl/ic_vector.sv
module ic_vector
    import ic_pkg::*;
#(
    parameter int ENTRY_SHIFT = 1
) (
    input  win_t             win_i,
    input  logic [VEC_W-1:0] base_i,
    input  fast_cfg_t        fast_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             fast_o
);

    logic [VEC_W-1:0] offset;
    assign offset = VEC_W'(win_i.src) << ENTRY_SHIFT;

    always_comb begin
        fast_o = win_i.valid && fast_i.en && (fast_i.src == win_i.src);
        if (!win_i.valid)
            vec_o = '0;
        else if (fast_o)
            vec_o = fast_i.vec;
        else
            vec_o = base_i + offset;
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import ic_pkg::*;
#(
    parameter int N_SRC       = 16,
    parameter int ENTRY_SHIFT = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SRC-1:0]      irq_i,
    input  logic [N_EXC-1:0]      exc_i,
    input  logic [N_DBG-1:0]      dbg_i,
    input  logic                  sw_lp_i,
    input  logic [2:0]            core_mask_i,
    input  logic                  ack_i,
    input  logic                  cfg_we_i,
    input  logic [2:0]            cfg_sel_i,
    input  logic [IDX_W-1:0]      cfg_idx_i,
    input  logic [15:0]           cfg_data_i,
    output logic                  req_o,
    output logic [IDX_W-1:0]      req_src_o,
    output logic [2:0]            req_lvl_o,
    output logic [VEC_W-1:0]      req_vec_o,
    output logic                  req_fast_o,
    output logic                  wake_o,
    output logic [2:0]            svc_lvl_o
);

    localparam int N_TOT = PERIPH_BASE + N_SRC;

    logic [N_SRC-1:0][1:0] prio;
    logic [N_SRC-1:0]      edge_cfg;
    logic [VEC_W-1:0]      base_q;
    fast_cfg_t             fast_q;
    logic [VEC_W-1:0]      fast_vec_q;

    ic_cfg #(.N_SRC(N_SRC)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cfg_we_i),
        .sel_i  (cfg_sel_i),
        .idx_i  (cfg_idx_i),
        .data_i (cfg_data_i),
        .prio_o (prio),
        .edge_o (edge_cfg),
        .base_o (base_q),
        .fast_o (fast_q)
    );
    assign fast_vec_q = fast_q.vec;

    logic [N_TOT-1:0]      line;
    logic [N_TOT-1:0]      edge_mode;
    logic [N_TOT-1:0]      enable;
    logic [N_TOT-1:0]      unmask;
    logic [N_TOT-1:0][2:0] lvl;

    for (genvar i = 0; i < N_TOT; i++) begin : g_map
        if (i < N_EXC) begin : g_exc
            assign line[i]      = exc_i[i];
            assign edge_mode[i] = 1'b1;
            assign enable[i]    = 1'b1;
            assign unmask[i]    = 1'b1;
            assign lvl[i]       = LVL_3;
        end else if (i < N_EXC + N_DBG) begin : g_dbg
            assign line[i]      = dbg_i[i-N_EXC];
            assign edge_mode[i] = 1'b0;
            assign enable[i]    = 1'b1;
            assign unmask[i]    = 1'b0;
            assign lvl[i]       = LVL_3;
        end else if (i == SRC_SW) begin : g_sw
            assign line[i]      = sw_lp_i;
            assign edge_mode[i] = 1'b0;
            assign enable[i]    = 1'b1;
            assign unmask[i]    = 1'b0;
            assign lvl[i]       = LVL_LP;
        end else begin : g_per
            assign line[i]      = irq_i[i-PERIPH_BASE];
            assign edge_mode[i] = edge_cfg[i-PERIPH_BASE];
            assign enable[i]    = prio[i-PERIPH_BASE] != 2'd0;
            assign unmask[i]    = 1'b0;
            assign lvl[i]       = code_to_lvl(prio[i-PERIPH_BASE]);
        end
    end

    logic             req_q;
    logic [IDX_W-1:0] src_q;
    logic [2:0]       lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic             fast_hit_q;
    logic             wake_q;
    logic [2:0]       svc_q;

    logic             take;
    assign take = ack_i && req_q;

    logic [N_TOT-1:0] active;

    ic_pending #(.N_TOT(N_TOT)) u_pend (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line),
        .edge_mode_i (edge_mode),
        .clr_i       (take),
        .clr_src_i   (src_q),
        .active_o    (active)
    );

    win_t win;
    logic wake_c;

    ic_arbiter #(.N_TOT(N_TOT)) u_arb (
        .active_i (active),
        .enable_i (enable),
        .unmask_i (unmask),
        .lvl_i    (lvl),
        .mask_i   (core_mask_i),
        .win_o    (win),
        .wake_o   (wake_c)
    );

    logic [VEC_W-1:0] vec_c;
    logic             fast_c;

    ic_vector #(.ENTRY_SHIFT(ENTRY_SHIFT)) u_vec (
        .win_i  (win),
        .base_i (base_q),
        .fast_i (fast_q),
        .vec_o  (vec_c),
        .fast_o (fast_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            src_q      <= '0;
            lvl_q      <= 3'd0;
            vec_q      <= '0;
            fast_hit_q <= 1'b0;
            wake_q     <= 1'b0;
            svc_q      <= 3'd0;
        end else begin
            req_q      <= win.valid;
            src_q      <= win.valid ? win.src : '0;
            lvl_q      <= win.valid ? win.lvl : LVL_LP;
            vec_q      <= vec_c;
            fast_hit_q <= fast_c;
            wake_q     <= wake_c;
            if (take)
                svc_q <= lvl_q;
        end
    end

    assign req_o      = req_q;
    assign req_src_o  = src_q;
    assign req_lvl_o  = lvl_q;
    assign req_vec_o  = vec_q;
    assign req_fast_o = fast_hit_q;
    assign wake_o     = wake_q;
    assign svc_lvl_o  = svc_q;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import ic_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ack_i,
    input logic [2:0]       core_mask_i,
    input logic             req_o,
    input logic [IDX_W-1:0] req_src_o,
    input logic [2:0]       req_lvl_o,
    input logic [VEC_W-1:0] req_vec_o,
    input logic             req_fast_o,
    input logic             wake_o,
    input logic [2:0]       svc_lvl_o,
    input logic [VEC_W-1:0] fast_vec_q
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !req_o |-> (!req_fast_o && req_vec_o == '0));

    p_mask_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (req_o && req_src_o >= IDX_W'(N_EXC)) |-> (req_lvl_o >= $past(core_mask_i)));

    p_exc_tier_r5: assert property (@(posedge clk) disable iff (rst)
        (req_o && req_src_o < IDX_W'(N_EXC + N_DBG)) |-> (req_lvl_o == 3'd4));

    p_sw_tier_r6: assert property (@(posedge clk) disable iff (rst)
        (req_o && req_src_o == IDX_W'(SRC_SW)) |-> (req_lvl_o == 3'd0));

    p_svc_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_i && req_o) |=> (svc_lvl_o == $past(req_lvl_o)));

    p_fast_vec_r10: assert property (@(posedge clk) disable iff (rst)
        (req_o && req_fast_o) |-> (req_vec_o == $past(fast_vec_q)));

    p_wake_cover_r11: assert property (@(posedge clk) disable iff (rst)
        req_o |-> wake_o);

endmodule

bind prio_intc prio_intc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack_i       (ack_i),
    .core_mask_i (core_mask_i),
    .req_o       (req_o),
    .req_src_o   (req_src_o),
    .req_lvl_o   (req_lvl_o),
    .req_vec_o   (req_vec_o),
    .req_fast_o  (req_fast_o),
    .wake_o      (wake_o),
    .svc_lvl_o   (svc_lvl_o),
    .fast_vec_q  (fast_vec_q)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;

    localparam int N_SRC = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_SRC-1:0]  irq_i = '0;
    logic [3:0]        exc_i = '0;
    logic [2:0]        dbg_i = '0;
    logic              sw_lp_i = 1'b0;
    logic [2:0]        core_mask_i = 3'd0;
    logic              ack_i = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [2:0]        cfg_sel_i = 3'd0;
    logic [7:0]        cfg_idx_i = 8'd0;
    logic [15:0]       cfg_data_i = 16'd0;
    logic              req_o;
    logic [7:0]        req_src_o;
    logic [2:0]        req_lvl_o;
    logic [15:0]       req_vec_o;
    logic              req_fast_o;
    logic              wake_o;
    logic [2:0]        svc_lvl_o;

    always #2 clk = ~clk;

    prio_intc #(.N_SRC(N_SRC)) u_dut (
        .clk(clk), .rst(rst), .irq_i(irq_i), .exc_i(exc_i), .dbg_i(dbg_i),
        .sw_lp_i(sw_lp_i), .core_mask_i(core_mask_i), .ack_i(ack_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_idx_i(cfg_idx_i),
        .cfg_data_i(cfg_data_i), .req_o(req_o), .req_src_o(req_src_o),
        .req_lvl_o(req_lvl_o), .req_vec_o(req_vec_o), .req_fast_o(req_fast_o),
        .wake_o(wake_o), .svc_lvl_o(svc_lvl_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, got, exp);
        end
    endtask

    task automatic expect_req(input string tag, input int src, input int lvl);
        chk(tag, "req", int'(req_o), 1);
        chk(tag, "src", int'(req_src_o), src);
        chk(tag, "lvl", int'(req_lvl_o), lvl);
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; irq_i = '0; exc_i = '0; dbg_i = '0; sw_lp_i = 1'b0;
        core_mask_i = 3'd0; ack_i = 1'b0; cfg_we_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg(input int sel, input int idx, input int data);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = 3'(sel); cfg_idx_i = 8'(idx); cfg_data_i = 16'(data);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        do_reset();
        settle();
        chk("R1", "req", int'(req_o), 0);
        chk("R1", "wake", int'(wake_o), 0);
        chk("R1", "vec", int'(req_vec_o), 0);
        chk("R1", "svc", int'(svc_lvl_o), 0);
        chk("R1", "fast", int'(req_fast_o), 0);
    endtask

    task automatic t_enable();
        do_reset();
        @(negedge clk); irq_i[2] = 1'b1;
        settle();
        chk("R2", "disabled req", int'(req_o), 0);
        chk("R11", "disabled wake", int'(wake_o), 0);
        cfg(0, 2, 2);
        settle();
        expect_req("R2", 10, 2);
    endtask

    task automatic t_arbitrate();
        do_reset();
        cfg(0, 2, 2); cfg(0, 5, 3); cfg(0, 1, 3);
        @(negedge clk); irq_i[2] = 1'b1; irq_i[5] = 1'b1; irq_i[1] = 1'b1;
        // R12: sample exactly on the second edge after the change
        @(posedge clk); @(negedge clk);
        chk("R12", "not yet", int'(req_o), 0);
        @(posedge clk); @(negedge clk);
        expect_req("R3", 9, 3);
        @(negedge clk); core_mask_i = 3'd4;
        settle();
        chk("R4", "masked req", int'(req_o), 0);
        chk("R11", "masked wake", int'(wake_o), 1);
        @(negedge clk); core_mask_i = 3'd3;
        settle();
        expect_req("R4", 9, 3);
        @(negedge clk); irq_i[1] = 1'b0;
        settle();
        expect_req("R3", 13, 3);
    endtask

    task automatic t_exceptions();
        do_reset();
        @(negedge clk); core_mask_i = 3'd7; exc_i[2] = 1'b1;
        @(negedge clk); exc_i[2] = 1'b0;
        settle();
        expect_req("R5", 2, 4);
        ack();
        chk("R8", "exc cleared", int'(req_o), 0);
        @(negedge clk); core_mask_i = 3'd5; dbg_i[1] = 1'b1;
        settle();
        chk("R5", "debug masked", int'(req_o), 0);
        chk("R11", "debug wake", int'(wake_o), 1);
        @(negedge clk); core_mask_i = 3'd4;
        settle();
        expect_req("R5", 5, 4);
        @(negedge clk); exc_i[0] = 1'b1; exc_i[3] = 1'b1;
        @(negedge clk); exc_i = '0;
        settle();
        expect_req("R3", 0, 4);
    endtask

    task automatic t_software();
        do_reset();
        @(negedge clk); sw_lp_i = 1'b1;
        settle();
        expect_req("R6", 7, 0);
        chk("R9", "sw vec", int'(req_vec_o), 14);
        @(negedge clk); core_mask_i = 3'd1;
        settle();
        chk("R6", "sw masked", int'(req_o), 0);
    endtask

    task automatic t_vectors();
        do_reset();
        cfg(2, 0, 16'h0100); cfg(0, 1, 3);
        @(negedge clk); irq_i[1] = 1'b1;
        settle();
        chk("R9", "vec", int'(req_vec_o), 16'h0112);
        cfg(2, 0, 16'h4000);
        settle();
        chk("R9", "relocated", int'(req_vec_o), 16'h4012);
        cfg(4, 0, 16'hBEEF); cfg(3, 0, 16'h0109);
        settle();
        chk("R10", "fast vec", int'(req_vec_o), 16'hBEEF);
        chk("R10", "fast flag", int'(req_fast_o), 1);
        cfg(0, 0, 3);
        @(negedge clk); irq_i[0] = 1'b1;
        settle();
        chk("R10", "other src flag", int'(req_fast_o), 0);
        chk("R10", "other src vec", int'(req_vec_o), 16'h4010);
    endtask

    task automatic t_nesting();
        do_reset();
        cfg(1, 3, 1); cfg(0, 3, 2); cfg(0, 4, 3); cfg(0, 5, 2);
        @(negedge clk); irq_i[3] = 1'b1;
        @(negedge clk); irq_i[3] = 1'b0;
        settle();
        expect_req("R8", 11, 2);
        ack();
        chk("R7", "svc tier", int'(svc_lvl_o), 2);
        chk("R8", "edge consumed", int'(req_o), 0);
        @(negedge clk); core_mask_i = 3'd3; irq_i[5] = 1'b1;
        settle();
        chk("R4", "lower blocked", int'(req_o), 0);
        @(negedge clk); irq_i[4] = 1'b1;
        settle();
        expect_req("R7", 12, 3);
        ack();
        chk("R7", "svc nested", int'(svc_lvl_o), 3);
    endtask

    task automatic t_capture();
        do_reset();
        cfg(1, 6, 1); cfg(0, 6, 1); cfg(0, 7, 1);
        @(negedge clk); irq_i[6] = 1'b1;
        @(negedge clk); irq_i[6] = 1'b0;
        settle();
        expect_req("R8", 14, 1);
        ack();
        chk("R8", "edge cleared", int'(req_o), 0);
        @(negedge clk); irq_i[7] = 1'b1;
        settle();
        expect_req("R8", 15, 1);
        @(negedge clk); irq_i[7] = 1'b0;
        settle();
        chk("R8", "level follows", int'(req_o), 0);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_arbitrate();
        t_exceptions();
        t_software();
        t_vectors();
        t_nesting();
        t_capture();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule